// File: doc/BRIEF.md
# Flash Self-Programming Command Register

This block sits between a microcontroller core and its flash controller and turns a single memory-mapped control byte into flash programming commands. Software writes the byte with the enable bit set and at most one command bit. It then issues a store-to-program-memory strobe (SPM) or a load-from-program-memory strobe (LPM) within a few cycles. The block captures the page and word address from the 16-bit Z pointer and sends one command to the flash side: buffer fill, page erase, page write, lock-bit set, read-while-write re-enable or signature read.

The block keeps the enable and command bits armed only for a short window after the write. If no strobe arrives in that window, the bits clear themselves. The block tracks whether the read-while-write section is busy and drives the read block for that section from this flag. Two different commands clear the flag. It also raises an interrupt request while the engine is idle and interrupts are enabled. A flash operation ends when the flash reports done. Until then, the block ignores new commands.

Top module: `selfprog_ctrl_top`

## Requirements
- R1: The register reads as {irqEn[7], rwwBusy[6], sigRd[5], rwwRe[4], lockSet[3], pgWrite[2], pgErase[1], spmEn[0]}. All bits are zero after reset. Bit 6 cannot be written and changes only by hardware.
- R2: `spmIrq` is high exactly while irqEn is 1, `globalIntEn` is 1 and spmEn is 0.
- R3: An accepted page-erase or page-write command sets rwwBusy in the same clock edge that issues it. `rwwReadBlock` follows rwwBusy.
- R4: rwwBusy is cleared when a re-enable command (rwwRe with spmEn) is issued, and also when a buffer-fill command (spmEn alone) is issued.
- R5: With sigRd and spmEn armed, an LPM on one of the first three edges after the write issues a signature read, with `flashByteSel` = Z[0]. An SPM in that state does nothing.
- R6: `flashPage` = Z[15:8]. A fill carries `flashWord` = Z[7:1]. Every other command carries word 0. `flashByteSel` is 0 for all commands except the signature read.
- R7: An SPM is accepted on edges 1 to 4 after the arming write. If no command has been issued by edge 4, bits 5..0 clear on that edge.
- R8: When more than one of bits 5..1 is set, no command is issued and the bits expire as in R7.
- R9: While an operation is active or `flashBusy` is high, a register write changes only irqEn, and strobes are ignored.
- R10: A `flashDone` pulse during an active operation clears bits 5..0.
- R11: A command appears on the edge after the strobe edge, as a one-cycle `flashCmdValid` pulse. The codes are fill=1, erase=2, write=3, lock=4, re-enable=5, signature=6.
- R12: A register write on the same edge as a strobe takes priority. The write re-arms the register and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register contents |
| globalIntEn | input | 1 | Core global interrupt flag |
| spmStrobe | input | 1 | SPM instruction strobe |
| lpmStrobe | input | 1 | LPM instruction strobe |
| zPtr | input | 16 | Z pointer |
| flashBusy | input | 1 | Flash operation in progress |
| flashDone | input | 1 | Flash operation finished (pulse) |
| flashCmdValid | output | 1 | Command valid pulse |
| flashCmd | output | 3 | Command code |
| flashPage | output | 8 | Page select |
| flashWord | output | 7 | Word within page |
| flashByteSel | output | 1 | Byte select for signature read |
| rwwReadBlock | output | 1 | Read-while-write section read block |
| spmIrq | output | 1 | SPM-ready interrupt request |

## Verification
Two events compete on the same edge in two places.

The first is the window expiry against a late strobe. The bench places an SPM exactly on the fourth edge, where the command must win. It then places one on the fifth edge, where the bits must already be cleared.

The second is an arming write against an SPM on the same edge. Here the bench checks that the new register value was loaded and that no command pulse followed.

A behavioural model checks both conflicts every cycle during a long random phase. In that phase, writes, strobes and flash completions often land together.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_FILL  = 3'd1,
    FC_ERASE = 3'd2,
    FC_WRITE = 3'd3,
    FC_LOCK  = 3'd4,
    FC_RWWEN = 3'd5,
    FC_SIG   = 3'd6
  } flashCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      loadCfg;
    logic      loadIrq;
    logic      clrCmd;
    logic      setBusy;
    logic      clrBusy;
    logic      issue;
    flashCmd_e cmd;
  } ctlStrobe_t;

  localparam int CFG_W    = 6;
  localparam int BIT_IRQ  = 7;
  localparam int BIT_BUSY = 6;

endpackage

// File: rtl/selfprog_ctl.sv
module selfprog_ctl
  import selfprog_pkg::*;
#(
  parameter int SPM_WIN = 4,
  parameter int LPM_WIN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] cfgBits,
  input  logic             spmStrobe,
  input  logic             lpmStrobe,
  input  logic             flashBusy,
  input  logic             flashDone,
  output ctlStrobe_t       strobe
);

  localparam int AGE_W = $clog2(SPM_WIN + 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(SPM_WIN - 1);
  localparam logic [AGE_W-1:0] AGE_LPM  = AGE_W'(LPM_WIN);

  logic             opActive;
  logic [AGE_W-1:0] age;
  logic             inProgress;
  logic             armed;
  logic [4:0]       cmdBits;
  flashCmd_e        selCmd;
  logic             spmHit;
  logic             lpmHit;
  logic             issue;
  logic             loadCfg;
  logic             expire;

  assign inProgress = opActive | flashBusy;
  assign armed      = cfgBits[0] & ~opActive;
  assign cmdBits    = cfgBits[5:1];
  assign loadCfg    = regWrEn & ~inProgress;

  // one-hot command decode; zero bits means buffer fill
  always_comb begin
    unique case (cmdBits)
      5'b00000: selCmd = FC_FILL;
      5'b00001: selCmd = FC_ERASE;
      5'b00010: selCmd = FC_WRITE;
      5'b00100: selCmd = FC_LOCK;
      5'b01000: selCmd = FC_RWWEN;
      5'b10000: selCmd = FC_SIG;
      default:  selCmd = FC_NONE;
    endcase
  end

  assign spmHit = spmStrobe & armed & ~inProgress & ~regWrEn &
                  (selCmd != FC_NONE) & (selCmd != FC_SIG);
  assign lpmHit = lpmStrobe & armed & ~inProgress & ~regWrEn &
                  (selCmd == FC_SIG) & (age < AGE_LPM);
  assign issue  = spmHit | lpmHit;
  assign expire = armed & (age == AGE_LAST) & ~issue & ~loadCfg;

  always_comb begin
    strobe.loadCfg = loadCfg;
    strobe.loadIrq = regWrEn;
    strobe.clrCmd  = expire | (opActive & flashDone);
    strobe.issue   = issue;
    strobe.cmd     = issue ? selCmd : FC_NONE;
    strobe.setBusy = issue & ((selCmd == FC_ERASE) | (selCmd == FC_WRITE));
    strobe.clrBusy = issue & ((selCmd == FC_FILL) | (selCmd == FC_RWWEN));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opActive <= 1'b0;
      age      <= '0;
    end else begin
      if (issue)          opActive <= 1'b1;
      else if (flashDone) opActive <= 1'b0;

      if (loadCfg)                        age <= '0;
      else if (armed && age != AGE_LAST)  age <= age + 1'b1;
    end
  end

endmodule

// File: rtl/selfprog_dp.sv
module selfprog_dp
  import selfprog_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int WORD_W = 7,
  localparam int Z_W   = PAGE_W + WORD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [7:0]        regWrData,
  input  logic [Z_W-1:0]    zPtr,
  output logic [7:0]        regVal,
  output logic              flashCmdValid,
  output flashCmd_e         flashCmd,
  output logic [PAGE_W-1:0] flashPage,
  output logic [WORD_W-1:0] flashWord,
  output logic              flashByteSel
);

  logic             irqEn;
  logic             rwwBusy;
  logic [CFG_W-1:0] cfg;

  assign regVal = {irqEn, rwwBusy, cfg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      rwwBusy <= 1'b0;
      cfg     <= '0;
    end else begin
      if (strobe.loadIrq) irqEn <= regWrData[BIT_IRQ];
      if (strobe.clrCmd)  cfg <= '0;
      if (strobe.loadCfg) cfg <= regWrData[CFG_W-1:0];
      if (strobe.setBusy)      rwwBusy <= 1'b1;
      else if (strobe.clrBusy) rwwBusy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashCmdValid <= 1'b0;
      flashCmd      <= FC_NONE;
      flashPage     <= '0;
      flashWord     <= '0;
      flashByteSel  <= 1'b0;
    end else begin
      flashCmdValid <= strobe.issue;
      if (strobe.issue) begin
        flashCmd     <= strobe.cmd;
        flashPage    <= zPtr[Z_W-1:WORD_W+1];
        flashWord    <= (strobe.cmd == FC_FILL) ? zPtr[WORD_W:1] : '0;
        flashByteSel <= (strobe.cmd == FC_SIG) ? zPtr[0] : 1'b0;
      end
    end
  end

endmodule

// File: rtl/selfprog_ctrl_top.sv
module selfprog_ctrl_top
  import selfprog_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int WORD_W  = 7,
  parameter int SPM_WIN = 4,
  parameter int LPM_WIN = 3,
  localparam int Z_W    = PAGE_W + WORD_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              globalIntEn,
  input  logic              spmStrobe,
  input  logic              lpmStrobe,
  input  logic [Z_W-1:0]    zPtr,
  input  logic              flashBusy,
  input  logic              flashDone,
  output logic              flashCmdValid,
  output logic [2:0]        flashCmd,
  output logic [PAGE_W-1:0] flashPage,
  output logic [WORD_W-1:0] flashWord,
  output logic              flashByteSel,
  output logic              rwwReadBlock,
  output logic              spmIrq
);

  ctlStrobe_t strobe;
  logic [7:0] regVal;
  flashCmd_e  cmdEnum;

  selfprog_ctl #(.SPM_WIN(SPM_WIN), .LPM_WIN(LPM_WIN)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .cfgBits   (regVal[CFG_W-1:0]),
    .spmStrobe (spmStrobe),
    .lpmStrobe (lpmStrobe),
    .flashBusy (flashBusy),
    .flashDone (flashDone),
    .strobe    (strobe)
  );

  selfprog_dp #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .regWrData     (regWrData),
    .zPtr          (zPtr),
    .regVal        (regVal),
    .flashCmdValid (flashCmdValid),
    .flashCmd      (cmdEnum),
    .flashPage     (flashPage),
    .flashWord     (flashWord),
    .flashByteSel  (flashByteSel)
  );

  assign regRdData    = regVal;
  assign flashCmd     = cmdEnum;
  assign rwwReadBlock = regVal[BIT_BUSY];
  assign spmIrq       = regVal[BIT_IRQ] & globalIntEn & ~regVal[0];

endmodule

// File: rtl/selfprog_chk.sv
module selfprog_chk #(
  parameter int WORD_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        regRdData,
  input logic              flashCmdValid,
  input logic [2:0]        flashCmd,
  input logic [WORD_W-1:0] flashWord,
  input logic              flashByteSel,
  input logic              rwwReadBlock
);

  // R11: one pulse per command, never back to back
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    flashCmdValid |=> !flashCmdValid);

  // R3: erase and write leave the section busy when they appear
  a_r3_busy_on_program: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmdValid && (flashCmd == 3'd2 || flashCmd == 3'd3)) |-> rwwReadBlock);

  // R4: fill and re-enable leave the section free
  a_r4_free_on_fill: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmdValid && (flashCmd == 3'd1 || flashCmd == 3'd5)) |-> !rwwReadBlock);

  // R6: only fill carries a word, only signature carries a byte select
  a_r6_word_zero: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmdValid && flashCmd != 3'd1) |-> (flashWord == '0));
  a_r6_byte_sel: assert property (@(posedge clk) disable iff (!rstN)
    (flashCmdValid && flashCmd != 3'd6) |-> !flashByteSel);

  // R8: a command only leaves from a one-hot (or empty) command field
  a_r8_single_cmd: assert property (@(posedge clk) disable iff (!rstN)
    flashCmdValid |-> ($countones(regRdData[5:1]) <= 1));

  // R10: enable stays set until the flash finishes
  a_r10_enable_held: assert property (@(posedge clk) disable iff (!rstN)
    flashCmdValid |-> regRdData[0]);

endmodule

bind selfprog_ctrl_top selfprog_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .regRdData     (regRdData),
  .flashCmdValid (flashCmdValid),
  .flashCmd      (flashCmd),
  .flashWord     (flashWord),
  .flashByteSel  (flashByteSel),
  .rwwReadBlock  (rwwReadBlock)
);

// File: tb/tb_selfprog_ctrl_top.sv
module tb_selfprog_ctrl_top;

  localparam int CLK_PERIOD = 10;
  localparam int FLASH_LAT  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic globalIntEn = 1'b0;
  logic spmStrobe = 1'b0;
  logic lpmStrobe = 1'b0;
  logic [15:0] zPtr = 16'h0000;
  logic flashBusy = 1'b0;
  logic flashDone = 1'b0;
  logic [7:0] regRdData;
  logic flashCmdValid;
  logic [2:0] flashCmd;
  logic [7:0] flashPage;
  logic [6:0] flashWord;
  logic flashByteSel;
  logic rwwReadBlock;
  logic spmIrq;

  selfprog_ctrl_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int issued = 0;
  int lastCmd = 0;
  int lastPage = 0;
  int lastWord = 0;
  int lastByte = 0;

  // behavioural reference state
  bit       mIrq, mBusy, mAct, mV, mByte;
  bit [5:0] mCfg;
  int       mAge, mCmd, pend;
  bit [7:0] mPage;
  bit [6:0] mWord;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int decodeCmd(input bit [4:0] c);
    case (c)
      5'b00000: return 1;
      5'b00001: return 2;
      5'b00010: return 3;
      5'b00100: return 4;
      5'b01000: return 5;
      5'b10000: return 6;
      default:  return 0;
    endcase
  endfunction

  task automatic cyc();
    bit inProg, armed, iss, wrOk;
    int code;
    bit [5:0] nCfg;
    flashDone = (pend == 1);
    flashBusy = (pend > 0);
    inProg = mAct || flashBusy;
    armed  = mCfg[0] && !mAct;
    code   = decodeCmd(mCfg[5:1]);
    wrOk   = regWrEn && !inProg;
    iss    = 1'b0;
    if (!regWrEn && armed && !inProg) begin
      if (spmStrobe && code != 0 && code != 6) iss = 1'b1;
      if (lpmStrobe && code == 6 && mAge < 3) iss = 1'b1;
    end
    nCfg = mCfg;
    if (mAct && flashDone) nCfg = '0;
    else if (armed && mAge == 3 && !iss && !wrOk) nCfg = '0;
    if (wrOk) nCfg = regWrData[5:0];
    @(posedge clk);
    if (regWrEn) mIrq = regWrData[7];
    if (iss && (code == 2 || code == 3)) mBusy = 1'b1;
    else if (iss && (code == 1 || code == 5)) mBusy = 1'b0;
    if (wrOk) mAge = 0;
    else if (armed && mAge != 3) mAge++;
    if (iss) mAct = 1'b1;
    else if (flashDone) mAct = 1'b0;
    if (mV) pend = FLASH_LAT;
    else if (pend > 0) pend--;
    mCfg = nCfg;
    mV = iss;
    if (iss) begin
      mCmd  = code;
      mPage = zPtr[15:8];
      mWord = (code == 1) ? zPtr[7:1] : 7'd0;
      mByte = (code == 6) ? zPtr[0] : 1'b0;
    end
    @(negedge clk);
    chk("R1 regRdData", regRdData, {mIrq, mBusy, mCfg});
    chk("R2 spmIrq", spmIrq, mIrq & globalIntEn & ~mCfg[0]);
    chk("R3 rwwReadBlock", rwwReadBlock, mBusy);
    chk("R11 flashCmdValid", flashCmdValid, mV);
    if (mV) begin
      chk("R11 flashCmd", flashCmd, mCmd);
      chk("R6 flashPage", flashPage, mPage);
      chk("R6 flashWord", flashWord, mWord);
      chk("R6 flashByteSel", flashByteSel, mByte);
    end
    if (flashCmdValid) begin
      issued++;
      lastCmd = flashCmd; lastPage = flashPage;
      lastWord = flashWord; lastByte = flashByteSel;
    end
    regWrEn = 1'b0; spmStrobe = 1'b0; lpmStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wrReg(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d; cyc();
  endtask

  task automatic spmAt(input logic [15:0] z);
    spmStrobe = 1'b1; zPtr = z; cyc();
  endtask

  task automatic lpmAt(input logic [15:0] z);
    lpmStrobe = 1'b1; zPtr = z; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n0;
    mIrq = 0; mBusy = 0; mAct = 0; mV = 0; mByte = 0; mCfg = '0;
    mAge = 0; mCmd = 0; pend = 0; mPage = '0; mWord = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset value", regRdData, 8'h00);
    chk("R2 reset irq", spmIrq, 0);
    rstN = 1'b1;
    idle(2);

    // R2 interrupt gating
    globalIntEn = 1'b1;
    wrReg(8'h80);
    chk("R2 irq idle", spmIrq, 1);
    wrReg(8'h81);
    chk("R2 irq low while enabled", spmIrq, 0);
    idle(4);
    chk("R7 expired enable", regRdData[0], 0);
    chk("R2 irq after expiry", spmIrq, 1);
    globalIntEn = 1'b0; idle(1);
    chk("R2 irq global off", spmIrq, 0);
    globalIntEn = 1'b1;

    // R1 busy bit read-only
    wrReg(8'hC0);
    chk("R1 busy not writable", regRdData[6], 0);

    // R3 page erase
    wrReg(8'h83); idle(1);
    spmAt(16'h1234);
    chk("R3 erase issued", lastCmd, 2);
    chk("R6 erase page", lastPage, 8'h12);
    chk("R6 erase word", lastWord, 0);
    chk("R3 busy set", rwwReadBlock, 1);
    idle(1);
    chk("R11 one-cycle pulse", flashCmdValid, 0);
    // R9 write during operation
    wrReg(8'h11);
    chk("R9 cfg kept", regRdData[5:0], 6'h03);
    n0 = issued; spmAt(16'h0000);
    chk("R9 strobe ignored", issued, n0);
    idle(5);
    chk("R10 cleared on done", regRdData[5:0], 0);
    chk("R3 busy held", rwwReadBlock, 1);

    // R4 re-enable
    wrReg(8'h11); spmAt(16'h0000);
    chk("R4 re-enable cmd", lastCmd, 5);
    chk("R4 busy cleared by re-enable", rwwReadBlock, 0);
    idle(5);

    // R6 page write ignores low Z
    wrReg(8'h05); spmAt(16'h56FF);
    chk("R6 write cmd", lastCmd, 3);
    chk("R6 write page", lastPage, 8'h56);
    chk("R6 write word zero", lastWord, 0);
    chk("R6 write byte sel", lastByte, 0);
    idle(5);

    // R4 fill clears busy, R6 word from Z
    wrReg(8'h01); spmAt(16'h00AB);
    chk("R4 fill cmd", lastCmd, 1);
    chk("R6 fill word", lastWord, 7'h55);
    chk("R4 busy cleared by fill", rwwReadBlock, 0);
    idle(5);

    // R5 signature read
    wrReg(8'h21);
    n0 = issued; spmAt(16'h0001);
    chk("R5 spm ignored", issued, n0);
    lpmAt(16'h0003);
    chk("R5 sig cmd", lastCmd, 6);
    chk("R5 byte sel", lastByte, 1);
    idle(5);
    wrReg(8'h21); idle(2); lpmAt(16'h0002);
    chk("R5 lpm on third edge", lastCmd, 6);
    idle(5);
    wrReg(8'h21); idle(3);
    n0 = issued; lpmAt(16'h0001);
    chk("R5 late lpm ignored", issued, n0);
    chk("R7 sig expired", regRdData[5:0], 0);

    // R7 window edges
    wrReg(8'h03); idle(3);
    n0 = issued; spmAt(16'h2000);
    chk("R7 fourth edge accepted", issued, n0 + 1);
    idle(5);
    wrReg(8'h03); idle(4);
    chk("R7 bits cleared", regRdData[5:0], 0);
    n0 = issued; spmAt(16'h2000);
    chk("R7 fifth edge ignored", issued, n0);

    // R8 invalid combination
    wrReg(8'h07);
    n0 = issued; spmAt(16'h3000);
    chk("R8 no command", issued, n0);
    chk("R8 bits held", regRdData[5:0], 6'h07);
    idle(3);
    chk("R8 expired", regRdData[5:0], 0);

    // R12 write and strobe together
    wrReg(8'h03);
    n0 = issued;
    regWrEn = 1'b1; regWrData = 8'h09; spmStrobe = 1'b1; cyc();
    idle(1);
    chk("R12 strobe dropped", issued, n0);
    chk("R12 write loaded", regRdData[5:0], 6'h09);
    spmAt(16'h4400);
    chk("R11 lock cmd", lastCmd, 4);
    idle(5);

    // random phase against the reference model
    for (int i = 0; i < 3000; i++) begin
      regWrEn   = ($urandom_range(0, 5) == 0);
      regWrData = 8'($urandom);
      if ($urandom_range(0, 1) == 0) regWrData[5:1] = 5'(1 << $urandom_range(0, 5));
      spmStrobe = ($urandom_range(0, 3) == 0);
      lpmStrobe = ($urandom_range(0, 4) == 0);
      zPtr      = 16'($urandom);
      if ($urandom_range(0, 15) == 0) globalIntEn = ~globalIntEn;
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule